// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block guards a transmitter against a station that never stops sending. It samples a synchronous transmit-activity input each clock and measures how long the activity lasts without a break. If the activity runs past a configurable limit, the block enters a jammed state. In that state it holds the transmitter disabled and raises an enable for the collision-signal generator.

The jammed state is sticky. It clears only after the transmit input has stayed quiet for an unbroken release interval. Any activity during that interval starts the wait again from zero. A one-cycle end-of-frame pulse marks the boundary between back-to-back frames, so a long run of frames separated only by these pulses does not count as one endless transmission.

Both limits are parameters expressed in clock cycles. By default they are derived from a clock-rate parameter: one fiftieth of a second for the activity limit and half a second for the release interval.

Top module: `txjab_guard`

## Requirements
- R1: While `rst_n` is low, `tx_disable`, `cd_jam_en` and `jab_flag` are all 0. Reset takes effect at once. Its release is taken through a two-flop synchronizer, so the first functional clock edge is the third rising edge after `rst_n` goes high.
- R2: When `tx_valid` is 1 and `tx_end` is 0 on JAB_CYC+1 consecutive rising edges, the block enters the jammed state at the last of those edges, and the outputs read 1 after that edge. A run of exactly JAB_CYC such edges does not trip.
- R3: A single edge with `tx_valid` at 0 clears the activity count. A later burst is then measured from zero and trips only after its own JAB_CYC+1 edges.
- R4: An edge with `tx_valid` and `tx_end` both at 1 ends the frame. It clears the activity count and cannot trip the block.
- R5: `tx_disable`, `cd_jam_en` and `jab_flag` are always equal. Each is 1 exactly while the block is jammed.
- R6: In the jammed state, the block returns to watching at the UNJAM_CYC-th consecutive rising edge with `tx_valid` at 0.
- R7: In the jammed state, any edge with `tx_valid` at 1 restarts the quiet count from zero and keeps the block jammed. `tx_end` has no effect while jammed.
- R8: After release, the activity count starts from zero. A burst of JAB_CYC active edges that begins right after release does not trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tx_valid | input | 1 | Transmit activity present this cycle |
| tx_end | input | 1 | One-cycle end-of-frame marker |
| tx_disable | output | 1 | Forces the transmitter off while jammed |
| cd_jam_en | output | 1 | Enables collision signalling while jammed |
| jab_flag | output | 1 | Jammed-state status |

## Verification
Bursts of activity are sized just under, exactly at, and just over the activity limit. The burst one cycle longer than the limit is the only one that trips, so these patterns pin down the trip cycle exactly. A gap of one idle cycle and a run of frames split only by end-of-frame pulses both show that the count restarts rather than accumulates. While jammed, a single active cycle placed late in the quiet interval, together with a stray end-of-frame pulse, tells a restarting release wait apart from a cumulative one. A burst of exactly the limit right after release shows whether the activity count was cleared on release.

// File: rtl/txjab_pkg.sv
package txjab_pkg;

  typedef enum logic {
    GUARD_WATCH  = 1'b0,
    GUARD_JAMMED = 1'b1
  } guard_state_e;

  // width needed to hold values 0..lim
  function automatic int unsigned cnt_w(input int unsigned lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/txjab_rst_sync.sv
module txjab_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_n_sync = chain_q[1];

endmodule

// File: rtl/txjab_span_cnt.sv
// Counts consecutive cycles with run high, saturating at LIMIT.
module txjab_span_cnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic reached
);

  localparam int unsigned W = txjab_pkg::cnt_w(LIMIT);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)                cnt_d = '0;
    else if (cnt_q != LIM_V) cnt_d = cnt_q + 1'b1;
  end

  assign cnt_en = run || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign reached = (cnt_q == LIM_V);

endmodule

// File: rtl/txjab_guard.sv
module txjab_guard #(
  parameter int unsigned CLK_HZ    = 25_000_000,
  parameter int unsigned JAB_CYC   = CLK_HZ / 50,
  parameter int unsigned UNJAM_CYC = CLK_HZ / 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_valid,
  input  logic tx_end,
  output logic tx_disable,
  output logic cd_jam_en,
  output logic jab_flag
);
  import txjab_pkg::*;

  localparam int unsigned IDLE_LIM = (UNJAM_CYC > 1) ? UNJAM_CYC - 1 : 0;

  logic         rst_int_n;
  guard_state_e state_q;
  guard_state_e state_d;
  logic         frame_live;
  logic         jab_run;
  logic         jab_reached;
  logic         idle_run;
  logic         idle_reached;

  txjab_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_int_n)
  );

  assign frame_live = tx_valid && !tx_end;
  assign jab_run    = (state_q == GUARD_WATCH) && frame_live;
  assign idle_run   = (state_q == GUARD_JAMMED) && !tx_valid;

  txjab_span_cnt #(.LIMIT(JAB_CYC)) u_jab_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (jab_run),
    .reached (jab_reached)
  );

  txjab_span_cnt #(.LIMIT(IDLE_LIM)) u_idle_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (idle_run),
    .reached (idle_reached)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GUARD_WATCH:  if (jab_run && jab_reached)   state_d = GUARD_JAMMED;
      GUARD_JAMMED: if (idle_run && idle_reached) state_d = GUARD_WATCH;
      default:      state_d = GUARD_WATCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= GUARD_WATCH;
    else            state_q <= state_d;
  end

  assign tx_disable = (state_q == GUARD_JAMMED);
  assign cd_jam_en  = (state_q == GUARD_JAMMED);
  assign jab_flag   = (state_q == GUARD_JAMMED);

endmodule

// File: rtl/txjab_guard_chk.sv
module txjab_guard_chk #(
  parameter int unsigned JAB_CYC   = 10,
  parameter int unsigned UNJAM_CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_end,
  input logic tx_disable,
  input logic cd_jam_en,
  input logic jab_flag
);

  int unsigned act_run;
  int unsigned quiet_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_run   <= 0;
      quiet_run <= 0;
    end else begin
      act_run   <= (!jab_flag && tx_valid && !tx_end) ? act_run + 1 : 0;
      quiet_run <= (jab_flag && !tx_valid) ? quiet_run + 1 : 0;
    end
  end

  assert_outputs_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_disable == jab_flag) && (cd_jam_en == jab_flag));

  assert_trip_after_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jab_flag) |-> (act_run == JAB_CYC + 1));

  assert_quiet_never_trips_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!jab_flag && !tx_valid) |=> !jab_flag);

  assert_frame_end_never_trips_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!jab_flag && tx_end) |=> !jab_flag);

  assert_activity_holds_jam_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (jab_flag && tx_valid) |=> jab_flag);

  assert_release_after_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jab_flag) |-> (quiet_run == UNJAM_CYC));

endmodule

bind txjab_guard txjab_guard_chk #(
  .JAB_CYC   (JAB_CYC),
  .UNJAM_CYC (UNJAM_CYC)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_valid   (tx_valid),
  .tx_end     (tx_end),
  .tx_disable (tx_disable),
  .cd_jam_en  (cd_jam_en),
  .jab_flag   (jab_flag)
);

// File: tb/txjab_guard_tb.sv
`timescale 1ns/1ps
module txjab_guard_tb_top;

  localparam int JAB   = 10;
  localparam int UNJAM = 8;
  localparam int MAX_CYC = 200000;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_valid;
  logic tx_end;
  logic tx_disable;
  logic cd_jam_en;
  logic jab_flag;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string phase_req = "R1";

  // reference model state
  int m_rel   = 0;
  int m_act   = 0;
  int m_quiet = 0;
  bit m_jam   = 1'b0;

  always #2 clk = ~clk;

  txjab_guard #(
    .CLK_HZ    (1000),
    .JAB_CYC   (JAB),
    .UNJAM_CYC (UNJAM)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .tx_end     (tx_end),
    .tx_disable (tx_disable),
    .cd_jam_en  (cd_jam_en),
    .jab_flag   (jab_flag)
  );

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_rel = 0; m_act = 0; m_quiet = 0; m_jam = 1'b0;
    end else if (m_rel < 2) begin
      m_rel = m_rel + 1;
    end else if (!m_jam) begin
      if (tx_valid && !tx_end) begin
        if (m_act >= JAB) begin m_jam = 1'b1; m_act = 0; m_quiet = 0; end
        else m_act = m_act + 1;
      end else m_act = 0;
    end else begin
      m_act = 0;
      if (tx_valid) m_quiet = 0;
      else if (m_quiet + 1 >= UNJAM) begin m_jam = 1'b0; m_quiet = 0; end
      else m_quiet = m_quiet + 1;
    end
  end

  task automatic check(input logic got, input logic exp, input string req, input string what);
    checks = checks + 1;
    if (got !== exp) begin
      fails = fails + 1;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, got, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n !== 1'bx) begin
      check(jab_flag,   m_jam, phase_req, "jab_flag");
      check(tx_disable, m_jam, "R5", "tx_disable");
      check(cd_jam_en,  m_jam, "R5", "cd_jam_en");
    end
  end

  task automatic drive(input logic v, input logic e, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_valid = v;
      tx_end   = e;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cyc >= MAX_CYC);
    fails = fails + 1;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tx_valid = 1'b0; tx_end = 1'b0;
    phase_req = "R1";
    drive(0, 0, 5);
    @(negedge clk); rst_n = 1'b1;
    drive(0, 0, 4);

    phase_req = "R3";          // short bursts, each restarts from zero
    drive(1, 0, 5);  drive(0, 0, 1);
    drive(1, 0, 8);  drive(0, 0, 1);
    drive(1, 0, JAB); drive(0, 0, 3);
    check(jab_flag, 1'b0, "R3", "burst of exactly the limit");

    phase_req = "R2";          // one over the limit trips
    drive(1, 0, JAB + 1);
    drive(1, 0, 3);
    check(jab_flag, 1'b1, "R2", "trip after limit+1");

    phase_req = "R7";          // late activity restarts the quiet wait
    drive(0, 0, UNJAM - 2);
    drive(1, 1, 1);
    drive(0, 0, UNJAM - 2);
    drive(0, 1, 1);
    check(jab_flag, 1'b1, "R7", "held after restart");

    phase_req = "R6";
    drive(0, 0, 3);
    check(jab_flag, 1'b0, "R6", "released after quiet interval");

    phase_req = "R8";          // count starts from zero after release
    drive(1, 0, JAB); drive(0, 0, 2);
    check(jab_flag, 1'b0, "R8", "no trip after release");

    phase_req = "R4";          // frames split by end pulses
    for (int k = 0; k < 6; k++) begin
      drive(1, 0, JAB - 2);
      drive(1, 1, 1);
    end
    drive(1, 0, JAB);
    drive(1, 1, 1);
    drive(0, 0, 2);
    check(jab_flag, 1'b0, "R4", "back-to-back frames");

    phase_req = "R5";
    drive(1, 0, 3 * JAB);
    check(cd_jam_en, 1'b1, "R5", "collision enable while jammed");
    drive(0, 0, UNJAM + 4);
    check(tx_disable, 1'b0, "R5", "transmitter enabled after release");

    phase_req = "R1";          // reset in the jammed state
    drive(1, 0, JAB + 3);
    @(negedge clk); rst_n = 1'b0; tx_valid = 1'b0;
    #1;
    check(jab_flag, 1'b0, "R1", "immediate clear on reset");
    drive(0, 0, 3);
    @(negedge clk); rst_n = 1'b1;
    drive(0, 0, 5);

    finish_run();
  end

endmodule